// File: doc/BRIEF.md
# Two-Register Compressed-Encoding 8-bit Processor

This block is a very small 8-bit execution engine with two architectural registers, R1 and R2. An outside agent presents one 16-bit instruction at a time, and the block decodes it from a subset of the compressed RISC-V layouts plus one custom display instruction. It has no fetch logic, program counter or memory. Two active-low strobes, sampled on the clock, split each instruction into two steps. While the execute strobe is low, the decoded result and its target are computed and placed in an internal holding register. While the update strobe is low, the held result is committed.

The 8-bit output normally shows R1. A display instruction can point it at either register. The next committed register write returns it to R1.

Top module: `cmini_core`

## Requirements
- R1: While rst_n is low at a clock edge, R1, R2 and the display select are cleared, so `disp_o` reads 0 afterwards.
- R2: A 5-bit register field selects R1 with 00001 and R2 with 00010; a 3-bit field (bits 9:7 or 4:2) selects R1 with 001 and R2 with 010; any other code makes the whole instruction ignored.
- R3: Load immediate (bits 15:13=010, 1:0=01, rd in 11:7) writes the 6-bit immediate {bit12, bits 6:2} sign-extended to 8 bits; 0x4095 gives R1=5 and 0x4135 gives R2=13.
- R4: Shifts are logical and zero-filling, with the amount taken from bits 4:2 only. Right shift is 100,x,00 in bits 15:10 with the register in 9:7 and op 01. Left shift is bits 15:13=000 with the register in 11:7 and op 10.
- R5: AND immediate (bits 15:13=100, 11:10=10, register in 9:7, op 01) ANDs the register with the sign-extended 6-bit immediate.
- R6: Register forms (bits 15:13=100, 11:10=11, rd in 9:7, rs2 in 4:2, op 01) compute rd-rs2 for bit12=1 with bits 6:5=00, rd+rs2 for bit12=1 with 01, and rd|rs2 for bit12=0 with 10, modulo 256; 0x9CA9 adds R2 into R1.
- R7: Move (bits 15:12=1000, rd in 11:7, rs in 6:2, op 10) copies rs into rd.
- R8: The display instruction (bits 15:7=100000000, rs in 6:2, op 11) makes `disp_o` show rs once committed; the next committed register write returns it to R1.
- R9: A low execute strobe alone never changes R1, R2 or the display; those change only when the update strobe is low.
- R10: An unrecognised encoding at execute leaves the holding register intact, so a following update commits the last valid result.
- R11: A cycle with both strobes low changes no state at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 16 | Instruction word |
| exe_n | input | 1 | Active-low execute strobe |
| upd_n | input | 1 | Active-low update (commit) strobe |
| disp_o | output | 8 | Displayed register value |

## Verification
The hardest situation to reach is the contents of R2 and the holding register, because neither appears directly on the output. The bench reads R2 by committing a display instruction for R2. It then reads R1 by committing a move of R1 onto itself, which also sends the display back to R1. The holding register is probed indirectly. The bench issues a valid execute and then a rejected encoding, an invalid register code, or a both-strobes-low cycle. It then applies one update and observes which value lands in the target register.

// File: rtl/cmini_pkg.sv
package cmini_pkg;
    localparam int XLEN   = 8;
    localparam int IW     = 16;
    localparam int NREG   = 2;
    localparam int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int SH_W   = $clog2(XLEN);
    localparam int IMM_W  = 6;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic [2:0] {
        OP_LI, OP_SRL, OP_SLL, OP_AND, OP_SUB, OP_ADD, OP_OR, OP_MV
    } alu_op_e;

    typedef enum logic [1:0] {
        K_NONE, K_WB, K_DISP
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        alu_op_e           op;
        ridx_t             dst;
        ridx_t             src;
        word_t             imm;
        logic [SH_W-1:0]   shamt;
    } uop_t;

    typedef struct packed {
        kind_e kind;
        ridx_t dst;
        word_t val;
    } hold_t;

    typedef struct packed {
        word_t [NREG-1:0] regs;
        ridx_t            sel;
        hold_t            hold;
    } state_t;

    function automatic logic code_ok(input logic [4:0] code);
        return (code >= 5'd1) && (32'(code) <= NREG);
    endfunction

    function automatic ridx_t code_idx(input logic [4:0] code);
        logic [4:0] t;
        t = code - 5'd1;
        return t[RIDX_W-1:0];
    endfunction
endpackage

// File: rtl/cmini_decode.sv
module cmini_decode
    import cmini_pkg::*;
(
    input  logic [IW-1:0] instr_i,
    output uop_t          uop_o
);
    logic [4:0]       full_rd, full_rs, cmp_rd, cmp_rs;
    logic [IMM_W-1:0] imm6;
    word_t            sext;

    always_comb begin
        full_rd = instr_i[11:7];
        full_rs = instr_i[6:2];
        cmp_rd  = {2'b00, instr_i[9:7]};
        cmp_rs  = {2'b00, instr_i[4:2]};
        imm6    = {instr_i[12], instr_i[6:2]};
        sext    = {{(XLEN-IMM_W){imm6[IMM_W-1]}}, imm6};

        uop_o       = '0;
        uop_o.kind  = K_NONE;
        uop_o.op    = OP_LI;
        uop_o.imm   = sext;
        uop_o.shamt = instr_i[2 +: SH_W];

        unique case (instr_i[1:0])
            2'b01: begin
                if (instr_i[15:13] == 3'b010) begin
                    if (code_ok(full_rd)) begin
                        uop_o.kind = K_WB;
                        uop_o.op   = OP_LI;
                        uop_o.dst  = code_idx(full_rd);
                        uop_o.src  = code_idx(full_rd);
                    end
                end else if (instr_i[15:13] == 3'b100) begin
                    unique case (instr_i[11:10])
                        2'b00, 2'b10: begin
                            if (code_ok(cmp_rd)) begin
                                uop_o.kind = K_WB;
                                uop_o.op   = (instr_i[11:10] == 2'b00) ? OP_SRL : OP_AND;
                                uop_o.dst  = code_idx(cmp_rd);
                                uop_o.src  = code_idx(cmp_rd);
                            end
                        end
                        2'b11: begin
                            if (code_ok(cmp_rd) && code_ok(cmp_rs)) begin
                                uop_o.dst = code_idx(cmp_rd);
                                uop_o.src = code_idx(cmp_rs);
                                if (instr_i[12] && instr_i[6:5] == 2'b00) begin
                                    uop_o.kind = K_WB;
                                    uop_o.op   = OP_SUB;
                                end else if (instr_i[12] && instr_i[6:5] == 2'b01) begin
                                    uop_o.kind = K_WB;
                                    uop_o.op   = OP_ADD;
                                end else if (!instr_i[12] && instr_i[6:5] == 2'b10) begin
                                    uop_o.kind = K_WB;
                                    uop_o.op   = OP_OR;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
            2'b10: begin
                if (instr_i[15:13] == 3'b000) begin
                    if (code_ok(full_rd)) begin
                        uop_o.kind = K_WB;
                        uop_o.op   = OP_SLL;
                        uop_o.dst  = code_idx(full_rd);
                        uop_o.src  = code_idx(full_rd);
                    end
                end else if (instr_i[15:12] == 4'b1000) begin
                    if (code_ok(full_rd) && code_ok(full_rs)) begin
                        uop_o.kind = K_WB;
                        uop_o.op   = OP_MV;
                        uop_o.dst  = code_idx(full_rd);
                        uop_o.src  = code_idx(full_rs);
                    end
                end
            end
            2'b11: begin
                if (instr_i[15:7] == 9'b100000000 && code_ok(full_rs)) begin
                    uop_o.kind = K_DISP;
                    uop_o.op   = OP_MV;
                    uop_o.dst  = code_idx(full_rs);
                    uop_o.src  = code_idx(full_rs);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cmini_alu.sv
module cmini_alu
    import cmini_pkg::*;
(
    input  alu_op_e         op_i,
    input  word_t           a_i,
    input  word_t           b_i,
    input  word_t           imm_i,
    input  logic [SH_W-1:0] shamt_i,
    output word_t           y_o
);
    always_comb begin
        unique case (op_i)
            OP_LI:   y_o = imm_i;
            OP_SRL:  y_o = a_i >> shamt_i;
            OP_SLL:  y_o = a_i << shamt_i;
            OP_AND:  y_o = a_i & imm_i;
            OP_SUB:  y_o = a_i - b_i;
            OP_ADD:  y_o = a_i + b_i;
            OP_OR:   y_o = a_i | b_i;
            OP_MV:   y_o = b_i;
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/cmini_core.sv
module cmini_core
    import cmini_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] instr_i,
    input  logic          exe_n,
    input  logic          upd_n,
    output logic [XLEN-1:0] disp_o
);
    state_t st_d, st_q;
    uop_t   uop;
    word_t  opnd_a, opnd_b, alu_y;
    logic   exe_go, upd_go;

    cmini_decode u_dec (
        .instr_i (instr_i),
        .uop_o   (uop)
    );

    assign opnd_a = st_q.regs[uop.dst];
    assign opnd_b = st_q.regs[uop.src];

    cmini_alu u_alu (
        .op_i    (uop.op),
        .a_i     (opnd_a),
        .b_i     (opnd_b),
        .imm_i   (uop.imm),
        .shamt_i (uop.shamt),
        .y_o     (alu_y)
    );

    always_comb begin
        st_d   = st_q;
        exe_go = !exe_n && upd_n;
        upd_go = !upd_n && exe_n;

        if (exe_go && uop.kind != K_NONE) begin
            st_d.hold.kind = uop.kind;
            st_d.hold.dst  = uop.dst;
            st_d.hold.val  = alu_y;
        end

        if (upd_go) begin
            unique case (st_q.hold.kind)
                K_WB: begin
                    st_d.regs[st_q.hold.dst] = st_q.hold.val;
                    st_d.sel                 = '0;
                end
                K_DISP: st_d.sel = st_q.hold.dst;
                default: ;
            endcase
            st_d.hold.kind = K_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign disp_o = st_q.regs[st_q.sel];
endmodule

// File: rtl/cmini_core_chk.sv
module cmini_core_chk
    import cmini_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  exe_n,
    input logic  upd_n,
    input word_t disp_o,
    input word_t r1,
    input word_t r2,
    input ridx_t sel
);
    logic rst_prev_q;
    always_ff @(posedge clk) rst_prev_q <= !rst_n;

    always_ff @(posedge clk) begin
        if (rst_prev_q && rst_n)
            AST_RESET_STATE: assert (disp_o == '0 && r1 == '0 && r2 == '0 && sel == '0); // R1
    end

    AST_EXE_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_n) |=> ($stable(r1) && $stable(r2) && $stable(sel))); // R9

    AST_BOTH_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!exe_n && !upd_n) |=> ($stable(r1) && $stable(r2) && $stable(sel))); // R11

    AST_WRITE_SHOWS_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(r1) || !$stable(r2)) |-> (sel == '0)); // R8

    AST_SEL_NEEDS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sel)) |-> $past(!upd_n && exe_n)); // R9
endmodule

bind cmini_core cmini_core_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .exe_n  (exe_n),
    .upd_n  (upd_n),
    .disp_o (disp_o),
    .r1     (st_q.regs[0]),
    .r2     (st_q.regs[1]),
    .sel    (st_q.sel)
);

// File: tb/cmini_core_bench.sv
module cmini_core_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr_i = '0;
    logic        exe_n = 1'b1;
    logic        upd_n = 1'b1;
    logic [7:0]  disp_o;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    cmini_core u_cmini_core (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i),
        .exe_n(exe_n), .upd_n(upd_n), .disp_o(disp_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] enc_li(input logic [4:0] rd, input logic [5:0] imm);
        return 16'h4001 | (16'(imm[5]) << 12) | (16'(rd) << 7) | (16'(imm[4:0]) << 2);
    endfunction
    function automatic logic [15:0] enc_srli(input logic [2:0] r, input logic [5:0] imm);
        return 16'h8001 | (16'(imm[5]) << 12) | (16'(r) << 7) | (16'(imm[4:0]) << 2);
    endfunction
    function automatic logic [15:0] enc_andi(input logic [2:0] r, input logic [5:0] imm);
        return 16'h8801 | (16'(imm[5]) << 12) | (16'(r) << 7) | (16'(imm[4:0]) << 2);
    endfunction
    function automatic logic [15:0] enc_slli(input logic [4:0] rd, input logic [5:0] imm);
        return 16'h0002 | (16'(imm[5]) << 12) | (16'(rd) << 7) | (16'(imm[4:0]) << 2);
    endfunction
    function automatic logic [15:0] enc_rr(input logic b12, input logic [1:0] fn,
                                           input logic [2:0] rd, input logic [2:0] rs);
        return 16'h8C01 | (16'(b12) << 12) | (16'(rd) << 7) | (16'(fn) << 5) | (16'(rs) << 2);
    endfunction
    function automatic logic [15:0] enc_mv(input logic [4:0] rd, input logic [4:0] rs);
        return 16'h8002 | (16'(rd) << 7) | (16'(rs) << 2);
    endfunction
    function automatic logic [15:0] enc_out(input logic [4:0] rs);
        return 16'h8003 | (16'(rs) << 2);
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [15:0] ins, input logic e, input logic u);
        @(negedge clk);
        instr_i = ins; exe_n = !e; upd_n = !u;
        @(negedge clk);
        exe_n = 1'b1; upd_n = 1'b1;
    endtask

    task automatic run(input logic [15:0] ins);
        pulse(ins, 1'b1, 1'b0);
        pulse(16'h0000, 1'b0, 1'b1);
    endtask

    task automatic read_r2(output logic [7:0] v);
        run(enc_out(5'd2));
        v = disp_o;
    endtask

    task automatic read_r1(output logic [7:0] v);
        run(enc_mv(5'd1, 5'd1));
        v = disp_o;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        run(enc_li(5'd1, 6'd9));
        run(enc_li(5'd2, 6'd4));
        do_reset();
        check(disp_o, 8'h00, "R1 disp after reset");
        read_r2(v); check(v, 8'h00, "R1 R2 after reset");
    endtask

    task automatic t_load();
        logic [7:0] v;
        run(16'h4095); check(disp_o, 8'h05, "R3 li r1 5");
        run(16'h4135); read_r2(v); check(v, 8'h0D, "R3 li r2 13");
        run(enc_li(5'd1, 6'h3D)); check(disp_o, 8'hFD, "R3 li negative");
        run(enc_li(5'd1, 6'h1F)); check(disp_o, 8'h1F, "R3 li max positive");
    endtask

    task automatic t_regreg();
        logic [7:0] v;
        run(16'h4095); run(16'h4135);
        run(16'h9CA9); check(disp_o, 8'h12, "R6 add 5+13");
        run(16'h4095);
        run(enc_rr(1'b1, 2'b00, 3'd1, 3'd2)); check(disp_o, 8'hF8, "R6 sub 5-13");
        run(enc_li(5'd1, 6'h30)); run(enc_li(5'd2, 6'h1F));
        run(enc_rr(1'b1, 2'b01, 3'd1, 3'd2)); check(disp_o, 8'h0F, "R6 add wrap");
        run(enc_li(5'd1, 6'h10)); run(enc_li(5'd2, 6'h0A));
        run(enc_rr(1'b0, 2'b10, 3'd1, 3'd2)); check(disp_o, 8'h1A, "R6 or");
        run(enc_rr(1'b1, 2'b01, 3'd2, 3'd1)); read_r2(v); check(v, 8'h24, "R6 add into r2");
    endtask

    task automatic t_shift_and();
        logic [7:0] v;
        run(enc_li(5'd1, 6'h3D));
        run(enc_srli(3'd1, 6'h0A)); check(disp_o, 8'h3F, "R4 srl by 2");
        run(enc_li(5'd1, 6'd5));
        run(enc_slli(5'd1, 6'h03)); check(disp_o, 8'h28, "R4 sll by 3");
        run(enc_li(5'd1, 6'h3D));
        run(enc_slli(5'd1, 6'h09)); check(disp_o, 8'hFA, "R4 sll upper imm bits unused");
        run(enc_li(5'd2, 6'h20));
        run(enc_srli(3'd2, 6'h07)); read_r2(v); check(v, 8'h01, "R4 srl zero fill r2");
        run(enc_li(5'd1, 6'h3D));
        run(enc_andi(3'd1, 6'h3C)); check(disp_o, 8'hFC, "R5 andi negative imm");
        run(enc_andi(3'd1, 6'h0F)); check(disp_o, 8'h0C, "R5 andi positive imm");
    endtask

    task automatic t_move_out();
        logic [7:0] v;
        run(enc_li(5'd1, 6'd22)); run(enc_li(5'd2, 6'd3));
        run(enc_mv(5'd2, 5'd1)); read_r2(v); check(v, 8'd22, "R7 mv r2<-r1");
        run(enc_li(5'd2, 6'd7));
        run(enc_out(5'd2)); check(disp_o, 8'd7, "R8 out shows r2");
        run(enc_li(5'd2, 6'd9)); check(disp_o, 8'd22, "R8 write returns display to r1");
        run(enc_out(5'd2)); run(enc_out(5'd1)); check(disp_o, 8'd22, "R8 out r1");
    endtask

    task automatic t_strobes();
        logic [7:0] v;
        run(enc_li(5'd1, 6'd5));
        pulse(enc_li(5'd1, 6'd7), 1'b1, 1'b0);
        check(disp_o, 8'd5, "R9 exe alone no change");
        pulse(16'h0000, 1'b0, 1'b0);
        check(disp_o, 8'd5, "R9 idle no change");
        pulse(16'h0000, 1'b0, 1'b1);
        check(disp_o, 8'd7, "R9 upd commits");
        pulse(enc_li(5'd1, 6'd9), 1'b1, 1'b0);
        pulse(enc_li(5'd1, 6'd3), 1'b1, 1'b1);
        check(disp_o, 8'd7, "R11 both low no write");
        pulse(16'h0000, 1'b0, 1'b1);
        check(disp_o, 8'd9, "R11 hold kept through both low");
        read_r2(v); check(v, 8'd0, "R11 r2 untouched");
    endtask

    task automatic t_invalid();
        logic [7:0] v;
        run(enc_li(5'd1, 6'd4)); run(enc_li(5'd2, 6'd6));
        pulse(enc_li(5'd1, 6'd11), 1'b1, 1'b0);
        pulse(16'hFFFF, 1'b1, 1'b0);
        pulse(16'h0000, 1'b0, 1'b1);
        check(disp_o, 8'd11, "R10 bad encoding keeps hold");
        pulse(enc_li(5'd1, 6'd12), 1'b1, 1'b0);
        pulse(enc_li(5'd3, 6'd1), 1'b1, 1'b0);
        pulse(16'h0000, 1'b0, 1'b1);
        check(disp_o, 8'd12, "R2 rd code 3 ignored");
        run(enc_li(5'd0, 6'd1)); check(disp_o, 8'd12, "R2 rd code 0 ignored");
        run(enc_srli(3'd3, 6'd1)); check(disp_o, 8'd12, "R2 compact code 3 ignored");
        run(enc_rr(1'b1, 2'b01, 3'd1, 3'd4)); check(disp_o, 8'd12, "R2 rs2 code 4 ignored");
        run(enc_out(5'd4)); check(disp_o, 8'd12, "R2 out code 4 ignored");
        read_r2(v); check(v, 8'd6, "R2 r2 untouched");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset();
        do_reset(); t_load();
        do_reset(); t_regreg();
        do_reset(); t_shift_and();
        do_reset(); t_move_out();
        do_reset(); t_strobes();
        do_reset(); t_invalid();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule